// File: doc/BRIEF.md
# Program Counter Pair Unit

This block keeps the current-instruction address and the following-instruction address of an in-order integer pipeline and moves the pair forward once per cycle. The pair is delayed: a taken control transfer changes the address two slots ahead, so the instruction right after the transfer still runs as a delay slot. The block also loads a trap vector on trap entry and restores both addresses on return from a trap.

On trap entry the unit issues, in the same cycle, a two-slot write request. It carries the outgoing current address and the outgoing next address, each tagged with a fixed local-register index in the trap window. The register file outside this block performs the writes. On return the caller supplies the two saved values and the unit loads them back. Each request names a target address, and that address must be word aligned. A misaligned target is flagged and ignored. When several requests arrive together, a fixed priority chooses one of them.

Top module: `pc_pair_unit`

## Requirements
- R1: While reset is active and after it is released, the current address reads 0 and the next address reads 4.
- R2: When adv_i is high and no other request is active, the current address takes the old next address and the next address becomes the old next address plus 4. When no input is active, both addresses hold.
- R3: When br_valid_i and adv_i are both high, the current address takes the old next address and the next address takes br_target_i. If br_valid_i is high without adv_i, both addresses hold.
- R4: On an accepted trap_req_i, whether or not adv_i is high, the current address takes trap_vec_i and the next address takes trap_vec_i plus 4.
- R5: In the cycle an accepted trap is presented, sav_we_o is 1. Slot 0 carries index 17 (local register 1) with the current address as data. Slot 1 carries index 18 (local register 2) with the next address as data. In every other cycle sav_we_o is 0.
- R6: On an accepted rett_req_i, the current address takes rett_pc_i and the next address takes rett_npc_i.
- R7: If the winning request's target has nonzero bits [1:0], align_err_o is 1 in that cycle, both addresses hold, and no save write is issued. The target is trap_vec_i for a trap, either restore value for a return, and br_target_i for a branch. Otherwise align_err_o is 0.
- R8: A trap wins over a return, a return wins over a branch, and a branch wins over a plain advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adv_i | input | 1 | Pipeline advance strobe |
| br_valid_i | input | 1 | Taken control transfer (acts with adv_i) |
| br_target_i | input | 32 | Transfer target address |
| trap_req_i | input | 1 | Trap entry request |
| trap_vec_i | input | 32 | Trap vector address |
| rett_req_i | input | 1 | Return-from-trap request |
| rett_pc_i | input | 32 | Restored current address |
| rett_npc_i | input | 32 | Restored next address |
| pc_o | output | 32 | Current instruction address |
| npc_o | output | 32 | Next instruction address |
| sav_we_o | output | 1 | Save write request for both slots |
| sav0_idx_o | output | 5 | Register index of save slot 0 |
| sav0_data_o | output | 32 | Data of save slot 0 (current address) |
| sav1_idx_o | output | 5 | Register index of save slot 1 |
| sav1_data_o | output | 32 | Data of save slot 1 (next address) |
| align_err_o | output | 1 | Misaligned target on the winning request |

## Verification
The save request and the alignment flag are combinational, so they are due in the same cycle as the stimulus. The bench drives inputs on the falling edge and samples these two outputs halfway through the low phase, before the rising edge. Both addresses change at the next rising edge. They are sampled on the following falling edge and compared with a model of the pair that the bench keeps itself. The idle cycles and rejected requests are checked the same way, by confirming that the pair holds at that falling edge.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
   typedef enum logic [2:0] {
      SEL_HOLD = 3'd0,
      SEL_ADV  = 3'd1,
      SEL_BR   = 3'd2,
      SEL_RETT = 3'd3,
      SEL_TRAP = 3'd4
   } pcu_sel_e;
endpackage

// File: rtl/pcu_arbiter.sv
module pcu_arbiter
   import pcu_pkg::*;
(
   input  logic     adv,
   input  logic     br_valid,
   input  logic     trap_req,
   input  logic     rett_req,
   output pcu_sel_e sel
);
   always_comb begin
      if (trap_req)
         sel = SEL_TRAP;
      else if (rett_req)
         sel = SEL_RETT;
      else if (br_valid && adv)
         sel = SEL_BR;
      else if (adv)
         sel = SEL_ADV;
      else
         sel = SEL_HOLD;
   end
endmodule

// File: rtl/pcu_align_chk.sv
module pcu_align_chk #(
   parameter int AW      = 32,
   parameter int AB      = 2,
   parameter bit ENABLE  = 1'b1
) (
   input  logic [AW-1:0] addr_a,
   input  logic [AW-1:0] addr_b,
   input  logic          use_b,
   output logic          bad
);
   initial begin
      if (AB < 1 || AB >= AW) $error("pcu_align_chk: AB out of range");
   end

   generate
      if (ENABLE) begin : g_check
         always_comb begin
            bad = |addr_a[AB-1:0];
            if (use_b && (|addr_b[AB-1:0]))
               bad = 1'b1;
         end
      end else begin : g_nocheck
         logic unused_ok;
         assign unused_ok = ^{addr_a, addr_b, use_b};
         assign bad = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/pcu_regs.sv
module pcu_regs
   import pcu_pkg::*;
#(
   parameter int          AW       = 32,
   parameter int          INC      = 4,
   parameter logic [31:0] RESET_PC = 32'h0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  pcu_sel_e      sel,
   input  logic          reject,
   input  logic [AW-1:0] br_target,
   input  logic [AW-1:0] trap_vec,
   input  logic [AW-1:0] rett_pc,
   input  logic [AW-1:0] rett_npc,
   output logic [AW-1:0] pc,
   output logic [AW-1:0] npc
);
   localparam logic [AW-1:0] STEP  = AW'(INC);
   localparam logic [AW-1:0] PC_R  = AW'(RESET_PC);
   localparam logic [AW-1:0] NPC_R = AW'(RESET_PC) + AW'(INC);

   logic [AW-1:0] pc_d, npc_d;

   always_comb begin
      pc_d  = pc;
      npc_d = npc;
      if (!reject) begin
         unique case (sel)
            SEL_TRAP: begin pc_d = trap_vec; npc_d = trap_vec + STEP; end
            SEL_RETT: begin pc_d = rett_pc;  npc_d = rett_npc;        end
            SEL_BR:   begin pc_d = npc;      npc_d = br_target;       end
            SEL_ADV:  begin pc_d = npc;      npc_d = npc + STEP;      end
            default:  begin pc_d = pc;       npc_d = npc;             end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc  <= PC_R;
         npc <= NPC_R;
      end else begin
         pc  <= pc_d;
         npc <= npc_d;
      end
   end
endmodule

// File: rtl/pc_pair_unit.sv
module pc_pair_unit
   import pcu_pkg::*;
#(
   parameter int          AW          = 32,
   parameter int          ALIGN_BITS  = 2,
   parameter int          RIW         = 5,
   parameter int          SAVE_IDX_PC = 17,
   parameter int          SAVE_IDX_NPC= 18,
   parameter logic [31:0] RESET_PC    = 32'h0,
   parameter bit          CHECK_ALIGN = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           adv_i,
   input  logic           br_valid_i,
   input  logic [AW-1:0]  br_target_i,
   input  logic           trap_req_i,
   input  logic [AW-1:0]  trap_vec_i,
   input  logic           rett_req_i,
   input  logic [AW-1:0]  rett_pc_i,
   input  logic [AW-1:0]  rett_npc_i,
   output logic [AW-1:0]  pc_o,
   output logic [AW-1:0]  npc_o,
   output logic           sav_we_o,
   output logic [RIW-1:0] sav0_idx_o,
   output logic [AW-1:0]  sav0_data_o,
   output logic [RIW-1:0] sav1_idx_o,
   output logic [AW-1:0]  sav1_data_o,
   output logic           align_err_o
);
   localparam int INC = 1 << ALIGN_BITS;

   initial begin
      if (AW < 8)                              $error("pc_pair_unit: AW too small");
      if (SAVE_IDX_PC  >= (1 << RIW))          $error("pc_pair_unit: SAVE_IDX_PC too wide");
      if (SAVE_IDX_NPC >= (1 << RIW))          $error("pc_pair_unit: SAVE_IDX_NPC too wide");
      if (SAVE_IDX_PC == SAVE_IDX_NPC)         $error("pc_pair_unit: save slots collide");
      if (RESET_PC % INC != 0)                 $error("pc_pair_unit: RESET_PC misaligned");
   end

   pcu_sel_e      sel;
   logic [AW-1:0] chk_a, chk_b;
   logic          chk_use_b;
   logic          bad;

   pcu_arbiter u_arb (
      .adv      (adv_i),
      .br_valid (br_valid_i),
      .trap_req (trap_req_i),
      .rett_req (rett_req_i),
      .sel      (sel)
   );

   always_comb begin
      chk_a     = '0;
      chk_b     = '0;
      chk_use_b = 1'b0;
      unique case (sel)
         SEL_TRAP: chk_a = trap_vec_i;
         SEL_RETT: begin chk_a = rett_pc_i; chk_b = rett_npc_i; chk_use_b = 1'b1; end
         SEL_BR:   chk_a = br_target_i;
         default:  chk_a = '0;
      endcase
   end

   pcu_align_chk #(.AW(AW), .AB(ALIGN_BITS), .ENABLE(CHECK_ALIGN)) u_align (
      .addr_a (chk_a),
      .addr_b (chk_b),
      .use_b  (chk_use_b),
      .bad    (bad)
   );

   pcu_regs #(.AW(AW), .INC(INC), .RESET_PC(RESET_PC)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (sel),
      .reject    (bad),
      .br_target (br_target_i),
      .trap_vec  (trap_vec_i),
      .rett_pc   (rett_pc_i),
      .rett_npc  (rett_npc_i),
      .pc        (pc_o),
      .npc       (npc_o)
   );

   assign align_err_o = bad;
   assign sav_we_o    = rst_n && (sel == SEL_TRAP) && !bad;
   assign sav0_idx_o  = RIW'(SAVE_IDX_PC);
   assign sav1_idx_o  = RIW'(SAVE_IDX_NPC);
   assign sav0_data_o = pc_o;
   assign sav1_data_o = npc_o;
endmodule

// File: rtl/pc_pair_chk.sv
module pc_pair_chk #(
   parameter int AW  = 32,
   parameter int RIW = 5
) (
   input logic           clk,
   input logic           rst_n,
   input logic           adv_i,
   input logic           br_valid_i,
   input logic [AW-1:0]  br_target_i,
   input logic           trap_req_i,
   input logic [AW-1:0]  trap_vec_i,
   input logic           rett_req_i,
   input logic [AW-1:0]  rett_pc_i,
   input logic [AW-1:0]  rett_npc_i,
   input logic [AW-1:0]  pc_o,
   input logic [AW-1:0]  npc_o,
   input logic           sav_we_o,
   input logic [AW-1:0]  sav0_data_o,
   input logic [AW-1:0]  sav1_data_o,
   input logic           align_err_o
);
   localparam logic [AW-1:0] STEP = AW'(4);

   p_reset_r1: assert property (@(posedge clk) !rst_n |=> (pc_o == '0 && npc_o == STEP));

   p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && !br_valid_i && !trap_req_i && !rett_req_i)
      |=> (pc_o == $past(npc_o) && npc_o == $past(npc_o) + STEP));

   p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv_i && !trap_req_i && !rett_req_i) |=> ($stable(pc_o) && $stable(npc_o)));

   p_branch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && br_valid_i && !trap_req_i && !rett_req_i && !align_err_o)
      |=> (pc_o == $past(npc_o) && npc_o == $past(br_target_i)));

   p_trap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_req_i && !align_err_o)
      |=> (pc_o == $past(trap_vec_i) && npc_o == $past(trap_vec_i) + STEP));

   p_save_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sav_we_o |-> (trap_req_i && sav0_data_o == pc_o && sav1_data_o == npc_o));

   p_save_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_req_i && !align_err_o) |-> sav_we_o);

   p_rett_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rett_req_i && !trap_req_i && !align_err_o)
      |=> (pc_o == $past(rett_pc_i) && npc_o == $past(rett_npc_i)));

   p_align_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      align_err_o |=> ($stable(pc_o) && $stable(npc_o)));

   p_align_nosave_r7: assert property (@(posedge clk) disable iff (!rst_n)
      align_err_o |-> !sav_we_o);

   p_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_o[1:0] == 2'b00 && npc_o[1:0] == 2'b00));

   p_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_req_i && rett_req_i && !align_err_o) |=> (pc_o == $past(trap_vec_i)));
endmodule

bind pc_pair_unit pc_pair_chk #(.AW(AW), .RIW(RIW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .adv_i       (adv_i),
   .br_valid_i  (br_valid_i),
   .br_target_i (br_target_i),
   .trap_req_i  (trap_req_i),
   .trap_vec_i  (trap_vec_i),
   .rett_req_i  (rett_req_i),
   .rett_pc_i   (rett_pc_i),
   .rett_npc_i  (rett_npc_i),
   .pc_o        (pc_o),
   .npc_o       (npc_o),
   .sav_we_o    (sav_we_o),
   .sav0_data_o (sav0_data_o),
   .sav1_data_o (sav1_data_o),
   .align_err_o (align_err_o)
);

// File: tb/tb_pc_pair_unit.sv
module tb_pc_pair_unit;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        adv_i, br_valid_i, trap_req_i, rett_req_i;
   logic [31:0] br_target_i, trap_vec_i, rett_pc_i, rett_npc_i;
   logic [31:0] pc_o, npc_o, sav0_data_o, sav1_data_o;
   logic [4:0]  sav0_idx_o, sav1_idx_o;
   logic        sav_we_o, align_err_o;

   int n_run = 0;
   int n_fail = 0;
   logic [31:0] m_pc, m_npc;

   always #10 clk = ~clk;

   pc_pair_unit dut (
      .clk(clk), .rst_n(rst_n), .adv_i(adv_i), .br_valid_i(br_valid_i),
      .br_target_i(br_target_i), .trap_req_i(trap_req_i), .trap_vec_i(trap_vec_i),
      .rett_req_i(rett_req_i), .rett_pc_i(rett_pc_i), .rett_npc_i(rett_npc_i),
      .pc_o(pc_o), .npc_o(npc_o), .sav_we_o(sav_we_o),
      .sav0_idx_o(sav0_idx_o), .sav0_data_o(sav0_data_o),
      .sav1_idx_o(sav1_idx_o), .sav1_data_o(sav1_data_o),
      .align_err_o(align_err_o)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic clear_in();
      adv_i = 0; br_valid_i = 0; trap_req_i = 0; rett_req_i = 0;
      br_target_i = 0; trap_vec_i = 0; rett_pc_i = 0; rett_npc_i = 0;
   endtask

   // Inputs are set at a falling edge; comb outputs checked mid low phase,
   // registered pair checked at the next falling edge.
   task automatic step(input string req, input logic exp_we, input logic exp_err);
      #5;
      check({req, " sav_we"}, 64'(sav_we_o), 64'(exp_we));
      check({req, " align_err"}, 64'(align_err_o), 64'(exp_err));
      if (exp_we) begin
         check({req, " sav0"}, {27'd0, sav0_idx_o, sav0_data_o}, {27'd0, 5'd17, m_pc});
         check({req, " sav1"}, {27'd0, sav1_idx_o, sav1_data_o}, {27'd0, 5'd18, m_npc});
      end
      @(negedge clk);
      clear_in();
   endtask

   task automatic check_pair(input string req);
      check({req, " pair"}, {pc_o, npc_o}, {m_pc, m_npc});
   endtask

   task automatic t_reset();
      rst_n = 0; clear_in();
      repeat (3) @(negedge clk);
      m_pc = 0; m_npc = 4;
      check_pair("R1 in reset");
      check("R1 no save in reset", 64'(sav_we_o), 64'd0);
      rst_n = 1;
      @(negedge clk);
      check_pair("R1 after release");
   endtask

   task automatic t_advance();
      for (int i = 0; i < 3; i++) begin
         adv_i = 1;
         step("R2 advance", 0, 0);
         m_pc = m_npc; m_npc = m_npc + 4;
         check_pair("R2 advance");
      end
      step("R2 idle", 0, 0);
      check_pair("R2 idle hold");
   endtask

   task automatic t_branch();
      br_valid_i = 1; br_target_i = 32'h0000_1000;
      step("R3 branch no adv", 0, 0);
      check_pair("R3 branch without adv ignored");
      adv_i = 1; br_valid_i = 1; br_target_i = 32'h0000_2000;
      step("R3 branch", 0, 0);
      m_pc = m_npc; m_npc = 32'h0000_2000;
      check_pair("R3 branch");
      adv_i = 1;
      step("R3 delay slot then target", 0, 0);
      m_pc = m_npc; m_npc = m_npc + 4;
      check_pair("R3 target reached");
   endtask

   task automatic t_trap();
      trap_req_i = 1; trap_vec_i = 32'h0000_8040;
      step("R5 trap save", 1, 0);
      m_pc = 32'h0000_8040; m_npc = 32'h0000_8044;
      check_pair("R4 trap load");
      adv_i = 1;
      step("R5 no save after trap", 0, 0);
      m_pc = m_npc; m_npc = m_npc + 4;
      check_pair("R2 advance in handler");
   endtask

   task automatic t_rett();
      rett_req_i = 1; rett_pc_i = 32'h0000_2004; rett_npc_i = 32'h0000_3000;
      step("R6 rett", 0, 0);
      m_pc = 32'h0000_2004; m_npc = 32'h0000_3000;
      check_pair("R6 rett restore");
   endtask

   task automatic t_align();
      adv_i = 1; br_valid_i = 1; br_target_i = 32'h0000_4002;
      step("R7 branch misaligned", 0, 1);
      check_pair("R7 branch hold");
      trap_req_i = 1; trap_vec_i = 32'h0000_9001;
      step("R7 trap misaligned no save", 0, 1);
      check_pair("R7 trap hold");
      rett_req_i = 1; rett_pc_i = 32'h0000_5000; rett_npc_i = 32'h0000_5003;
      step("R7 rett misaligned", 0, 1);
      check_pair("R7 rett hold");
   endtask

   task automatic t_priority();
      adv_i = 1; br_valid_i = 1; br_target_i = 32'h100; rett_req_i = 1;
      rett_pc_i = 32'h200; rett_npc_i = 32'h204; trap_req_i = 1; trap_vec_i = 32'h300;
      step("R8 trap wins", 1, 0);
      m_pc = 32'h300; m_npc = 32'h304;
      check_pair("R8 trap wins");
      adv_i = 1; br_valid_i = 1; br_target_i = 32'h100; rett_req_i = 1;
      rett_pc_i = 32'h200; rett_npc_i = 32'h208;
      step("R8 rett over branch", 0, 0);
      m_pc = 32'h200; m_npc = 32'h208;
      check_pair("R8 rett over branch");
      adv_i = 1; br_valid_i = 1; br_target_i = 32'h500; rett_req_i = 1;
      rett_pc_i = 32'h202; rett_npc_i = 32'h208;
      step("R8 misaligned rett blocks branch", 0, 1);
      check_pair("R8 lower request not taken");
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_advance();
      t_branch();
      t_trap();
      t_rett();
      t_align();
      t_priority();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule